// File: doc/BRIEF.md
# Serially Programmed Reference Divider

This block divides a crystal clock down to the comparison frequency of a frequency synthesizer. A host sends a 23-bit control word over three wires: a serial clock, a data line and a latch strobe. The last bit of the word selects a target register. When that bit is 0, the word carries an 11-bit reference count and a two-bit test pattern, and the rising edge of the latch strobe commits them. The divider is a fixed divide-by-8 prescaler followed by a programmable down-counter. One comparison pulse therefore comes out every 8 × count crystal cycles.

The three serial inputs are asynchronous to the crystal clock. They are synchronised and edge-detected in the crystal domain, so the serial clock must run well below the crystal rate. A new count is held pending and is adopted only when the programmable counter reaches its terminal count. Every period already in progress finishes at its old length.

Top module: `serial_ref_divider`

## Requirements
- R1: Words are shifted in first bit first, one bit per rising serial-clock edge. Shifting alone changes nothing. The word takes effect only on a rising edge of the latch strobe.
- R2: A word whose last bit (bit 23) is 1 is not for this register. Latching it changes neither the division ratio nor the test flag.
- R3: Bits 10..20 of the word form the count, with bit 10 as the MSB. The refPulse period equals 8 × count crystal cycles.
- R4: Bits 1..7, 21 and 22 are ignored. Setting them to 1 changes neither the period nor the test flag.
- R5: Every accepted word updates testMode. The flag is 0 exactly when bit 8 = 1 and bit 9 = 0, and 1 for the other three patterns.
- R6: A count of 0..4 is raised to 5, giving a period of 40 crystal cycles.
- R7: A newly latched count is adopted only at the next terminal count. The period running when the word arrives keeps its old length.
- R8: refPulse is high for exactly one crystal cycle per division period.
- R9: After reset, refPulse and testMode are 0. The count is 5, so the first periods are 40 cycles long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkXtal | input | 1 | Crystal clock, drives all logic |
| rst | input | 1 | Synchronous reset, active high |
| serClk | input | 1 | Serial shift clock (asynchronous) |
| serData | input | 1 | Serial data, first bit first |
| serLatch | input | 1 | Latch strobe, commits on its rising edge |
| refPulse | output | 1 | One-cycle comparison pulse every 8 × count cycles |
| testMode | output | 1 | High when the last accepted test bits are not 1,0 |

## Verification
The bench sweeps small counts and a handful of large ones, comparing each measured pulse spacing against 8 × count. A design that forgot the prescaler, counted one extra tick, or reversed the bit order would miss these values. Counts below five must give 40 cycles; a missing clamp shows up as a short or stuck period. A word is loaded halfway through a long period, and the bench checks that this period still closes at its old length, which catches a design that reloads immediately. The bench also checks that words with select bit 1, words with junk in the reserved bits, and words shifted in without a latch strobe disturb neither the period nor the flag. All four test-bit patterns are driven to expose an inverted or single-bit decode of the flag.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int FRAME_W = 23;
  localparam int CNT_W   = 11;
  // index in the shift register of word bit k is FRAME_W - k
  localparam int SEL_IDX     = FRAME_W - 23;
  localparam int CNT_MSB_IDX = FRAME_W - 10;
  localparam int CNT_LSB_IDX = CNT_MSB_IDX - CNT_W + 1;
  localparam int T8_IDX      = FRAME_W - 8;
  localparam int T9_IDX      = FRAME_W - 9;

  typedef struct packed {
    logic             load;
    logic [CNT_W-1:0] count;
  } ctrlStrobe_t;
endpackage

// File: rtl/refdiv_ctrl.sv
module refdiv_ctrl
  import refdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_COUNT   = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        serClk,
  input  logic        serData,
  input  logic        serLatch,
  output ctrlStrobe_t stb,
  output logic        testMode
);
  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_COUNT);

  logic [SYNC_STAGES:0] clkSync, dataSync, latchSync;
  logic [FRAME_W-1:0]   shReg;
  logic                 clkRise, latchRise, accept;
  logic [CNT_W-1:0]     rawCount, clampCount;

  always_ff @(posedge clk) begin
    if (rst) begin
      clkSync   <= '0;
      dataSync  <= '0;
      latchSync <= '0;
    end else begin
      clkSync   <= {clkSync[SYNC_STAGES-1:0], serClk};
      dataSync  <= {dataSync[SYNC_STAGES-1:0], serData};
      latchSync <= {latchSync[SYNC_STAGES-1:0], serLatch};
    end
  end

  assign clkRise   = clkSync[SYNC_STAGES-1] & ~clkSync[SYNC_STAGES];
  assign latchRise = latchSync[SYNC_STAGES-1] & ~latchSync[SYNC_STAGES];
  assign accept    = latchRise & ~shReg[SEL_IDX];
  assign rawCount  = shReg[CNT_MSB_IDX:CNT_LSB_IDX];
  assign clampCount = (rawCount < MIN_CNT) ? MIN_CNT : rawCount;

  always_ff @(posedge clk) begin
    if (rst) begin
      shReg    <= '0;
      stb      <= '0;
      testMode <= 1'b0;
    end else begin
      if (clkRise) shReg <= {shReg[FRAME_W-2:0], dataSync[SYNC_STAGES-1]};
      stb.load <= accept;
      if (accept) begin
        stb.count <= clampCount;
        testMode  <= ~(shReg[T8_IDX] & ~shReg[T9_IDX]);
      end
    end
  end

  // R5 / R2: the flag only moves one cycle after an accepted latch edge
  p_flag_on_accept_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(testMode) |-> $past(latchRise && !shReg[SEL_IDX]));
  // R6: a load never carries a count below the minimum
  p_load_min_r6: assert property (@(posedge clk) disable iff (rst)
    stb.load |-> stb.count >= MIN_CNT);
  // R1: a load strobe only follows a latch edge
  p_load_after_latch_r1: assert property (@(posedge clk) disable iff (rst)
    stb.load |-> $past(latchRise));
endmodule

// File: rtl/refdiv_dpath.sv
module refdiv_dpath
  import refdiv_pkg::*;
#(
  parameter int PRE_W       = 3,
  parameter int RESET_COUNT = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  ctrlStrobe_t stb,
  output logic        refPulse
);
  localparam logic [CNT_W-1:0] RST_CNT = CNT_W'(RESET_COUNT);

  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] activeCount, pendCount, cnt, nextCount;
  logic             pendValid, preWrap, terminalHit;

  assign preWrap     = &pre;
  assign terminalHit = preWrap && (cnt == '0);
  assign nextCount   = pendValid ? pendCount : activeCount;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre         <= '0;
      activeCount <= RST_CNT;
      pendCount   <= RST_CNT;
      pendValid   <= 1'b0;
      cnt         <= RST_CNT - 1'b1;
      refPulse    <= 1'b0;
    end else begin
      pre      <= pre + 1'b1;
      refPulse <= terminalHit;
      if (preWrap) begin
        if (cnt == '0) begin
          cnt         <= nextCount - 1'b1;
          activeCount <= nextCount;
          pendValid   <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
      if (stb.load) begin
        pendCount <= stb.count;
        pendValid <= 1'b1;
      end
    end
  end

  // R8: the pulse never lasts two cycles
  p_pulse_one_wide_r8: assert property (@(posedge clk) disable iff (rst)
    refPulse |=> !refPulse);
  // R3: pulses line up with the prescaler wrap
  p_pulse_on_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    refPulse |-> $past(preWrap));
  // R7: the active ratio changes only at a terminal count
  p_swap_at_terminal_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(activeCount) |-> $past(terminalHit));
endmodule

// File: rtl/serial_ref_divider.sv
module serial_ref_divider
  import refdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PRE_W       = 3,
  parameter int MIN_COUNT   = 5
) (
  input  logic clkXtal,
  input  logic rst,
  input  logic serClk,
  input  logic serData,
  input  logic serLatch,
  output logic refPulse,
  output logic testMode
);
  ctrlStrobe_t stb;

  refdiv_ctrl #(.SYNC_STAGES(SYNC_STAGES), .MIN_COUNT(MIN_COUNT)) i_ctrl (
    .clk(clkXtal), .rst(rst), .serClk(serClk), .serData(serData),
    .serLatch(serLatch), .stb(stb), .testMode(testMode)
  );

  refdiv_dpath #(.PRE_W(PRE_W), .RESET_COUNT(MIN_COUNT)) i_dpath (
    .clk(clkXtal), .rst(rst), .stb(stb), .refPulse(refPulse)
  );
endmodule

// File: tb/test_serial_ref_divider.sv
module test_serial_ref_divider;
  logic clk = 1'b0, rst = 1'b1;
  logic serClk = 1'b0, serData = 1'b0, serLatch = 1'b0;
  logic refPulse, testMode;
  int   errors = 0, checks = 0;

  always #4 clk = ~clk;

  serial_ref_divider i_serial_ref_divider (
    .clkXtal(clk), .rst(rst), .serClk(serClk), .serData(serData),
    .serLatch(serLatch), .refPulse(refPulse), .testMode(testMode)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [22:0] mkFrame(input int count, input bit t8,
      input bit t9, input bit sel, input bit junk);
    logic [22:0] f;
    f        = '0;
    f[22:16] = {7{junk}};
    f[15]    = t8;
    f[14]    = t9;
    f[13:3]  = 11'(count);
    f[2:1]   = {2{junk}};
    f[0]     = sel;
    return f;
  endfunction

  task automatic sendFrame(input logic [22:0] frm, input bit doLatch, output int el);
    el = 0;
    for (int i = 22; i >= 0; i--) begin
      serData = frm[i];
      repeat (4) begin @(negedge clk); el++; end
      serClk = 1'b1;
      repeat (4) begin @(negedge clk); el++; end
      serClk = 1'b0;
    end
    serLatch = doLatch;
    repeat (4) begin @(negedge clk); el++; end
    serLatch = 1'b0;
    repeat (4) begin @(negedge clk); el++; end
  endtask

  task automatic waitPulse(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!refPulse);
  endtask

  task automatic measure(output int p);
    int d;
    waitPulse(d);
    waitPulse(d);
    waitPulse(p);
  endtask

  task automatic load(input logic [22:0] frm);
    int el;
    sendFrame(frm, 1'b1, el);
  endtask

  initial begin
    int p, el, rest;
    bit exp;
    repeat (3) @(negedge clk);
    chk("R9 refPulse after reset", int'(refPulse), 0);
    chk("R9 testMode after reset", int'(testMode), 0);
    rst = 1'b0;
    measure(p);
    chk("R9 default period", p, 40);
    @(negedge clk);
    chk("R8 pulse width", int'(refPulse), 0);

    for (int n = 5; n <= 12; n++) begin
      load(mkFrame(n, 1, 0, 0, 0));
      measure(p);
      chk($sformatf("R3 period count %0d", n), p, 8 * n);
    end
    load(mkFrame(192, 1, 0, 0, 0));
    measure(p);
    chk("R3 period count 192", p, 1536);
    load(mkFrame(2047, 1, 0, 0, 0));
    measure(p);
    chk("R3 period count 2047", p, 16376);

    for (int n = 0; n <= 4; n++) begin
      load(mkFrame(n, 1, 0, 0, 0));
      measure(p);
      chk($sformatf("R6 clamp count %0d", n), p, 40);
    end

    load(mkFrame(9, 1, 0, 0, 1));
    measure(p);
    chk("R4 junk bits period", p, 72);
    chk("R4 junk bits flag", int'(testMode), 0);

    load(mkFrame(20, 0, 0, 1, 0));
    measure(p);
    chk("R2 deselected period", p, 72);
    chk("R2 deselected flag", int'(testMode), 0);

    sendFrame(mkFrame(30, 1, 0, 0, 0), 1'b0, el);
    measure(p);
    chk("R1 no latch no change", p, 72);

    for (int t = 0; t < 4; t++) begin
      exp = !(t[1] == 1'b1 && t[0] == 1'b0);
      load(mkFrame(7, t[1], t[0], 0, 0));
      @(negedge clk);
      chk($sformatf("R5 test bits %0d%0d", t[1], t[0]), int'(testMode), int'(exp));
    end
    load(mkFrame(7, 1, 0, 0, 0));
    chk("R5 flag cleared", int'(testMode), 0);

    load(mkFrame(192, 1, 0, 0, 0));
    measure(p);
    waitPulse(rest);
    sendFrame(mkFrame(6, 1, 0, 0, 0), 1'b1, el);
    waitPulse(rest);
    chk("R7 old period kept", el + rest, 1536);
    waitPulse(p);
    chk("R7 new period next", p, 48);
    @(negedge clk);
    chk("R8 pulse width short", int'(refPulse), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule